// File: doc/BRIEF.md
# Execute Unit with Compare Flags and Jump Resolution

This block is the arithmetic stage of a small 16-bit processor core. For each request it takes two operands and a 3-bit operation select. It produces a result and tells the caller whether that result is to be written back to the first operand's register. The operations are add, subtract, bitwise and, bitwise or and bitwise invert. A compare operation writes nothing. It only records two held flags, one for unsigned below and one for equal.

A jump request checks a 3-bit condition code against those held flags. It reports whether the jump is taken and selects the next instruction address: the jump target when taken, otherwise the fall-through address. An unused condition code, or the unused operation select, raises an illegal pulse instead. Each request is a one-cycle strobe on `start_i`, and every output for it is valid on the cycle that follows.

Top module: `alu_branch_unit`

## Requirements
- R1: After reset `valid_o`, `wr_en_o`, `taken_o`, `illegal_o`, `below_o`, `equal_o`, `result_o` and `ip_o` are all zero. One clock edge after `start_i` is sampled high, `valid_o` is high for exactly one cycle.
- R2: With `op_i` 000 (add) or 001 (subtract), `result_o` is `a_i+b_i` or `a_i-b_i` modulo 2^16, and `wr_en_o` is high. There is no carry or overflow output.
- R3: With `op_i` 010 (and), 011 (or) or 100 (invert `a_i`), `result_o` is the bitwise result and `wr_en_o` is high.
- R4: With `op_i` 101 (compare), `wr_en_o` stays low. `below_o` becomes 1 exactly when `a_i < b_i` as unsigned values, and `equal_o` becomes 1 exactly when `a_i == b_i`.
- R5: Only a compare changes `below_o` and `equal_o`. Arithmetic, logic and jump requests leave both flags unchanged, and so do idle cycles.
- R6: With `op_i` 110 (jump), `cond_i` selects the condition from the held flags. The codes are 000 always, 001 equal, 010 not equal, 011 below, 100 below or equal, 101 above (neither below nor equal), and 110 above or equal (not below). `taken_o` pulses when the condition holds.
- R7: A jump with `cond_i` 111 pulses `illegal_o` and leaves `taken_o` low.
- R8: On a jump request, `ip_o` takes `target_i` when the jump is taken and `fall_ip_i` otherwise. `ip_o` holds its value between jump requests.
- R9: With `op_i` 111, `illegal_o` pulses, `wr_en_o` stays low and the flags are unchanged.
- R10: `below_o` and `equal_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request strobe |
| op_i | input | 3 | Operation select |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cond_i | input | 3 | Jump condition code |
| target_i | input | 16 | Jump target address |
| fall_ip_i | input | 16 | Fall-through address |
| result_o | output | 16 | Operation result |
| wr_en_o | output | 1 | Write back result to first operand |
| valid_o | output | 1 | Outputs valid for the last request |
| below_o | output | 1 | Held unsigned-below flag |
| equal_o | output | 1 | Held equal flag |
| taken_o | output | 1 | Jump taken |
| illegal_o | output | 1 | Illegal code seen |
| ip_o | output | 16 | Next instruction address |

## Verification
The assertions assume that requests arrive as single-cycle strobes with operands stable around the sampling edge. They also assume that no jump is issued in the same cycle as a compare, since there is one request per cycle. The flag checks compare the outputs against the operands sampled on the previous edge, so they depend on the inputs being driven away from the clock edge. The bench drives every input on the falling edge and lowers `start_i` again before the next rising edge, which satisfies all of these assumptions.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned COND_W = 3;

  localparam logic [OP_W-1:0] OP_ADD = 3'b000;
  localparam logic [OP_W-1:0] OP_SUB = 3'b001;
  localparam logic [OP_W-1:0] OP_AND = 3'b010;
  localparam logic [OP_W-1:0] OP_OR  = 3'b011;
  localparam logic [OP_W-1:0] OP_NOT = 3'b100;
  localparam logic [OP_W-1:0] OP_CMP = 3'b101;
  localparam logic [OP_W-1:0] OP_JCC = 3'b110;
  localparam logic [OP_W-1:0] OP_BAD = 3'b111;

  localparam logic [COND_W-1:0] CC_ALWAYS = 3'b000;
  localparam logic [COND_W-1:0] CC_EQ     = 3'b001;
  localparam logic [COND_W-1:0] CC_NE     = 3'b010;
  localparam logic [COND_W-1:0] CC_LT     = 3'b011;
  localparam logic [COND_W-1:0] CC_LE     = 3'b100;
  localparam logic [COND_W-1:0] CC_GT     = 3'b101;
  localparam logic [COND_W-1:0] CC_GE     = 3'b110;
  localparam logic [COND_W-1:0] CC_BAD    = 3'b111;

  typedef struct packed {
    logic below;
    logic equal;
  } flags_t;
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_o
);
  always_comb begin
    res_o = '0;
    wr_o  = 1'b1;
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_NOT:  res_o = ~a_i;
      default: wr_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output flags_t            flags_o
);
  flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (upd_i) begin
      flags_q.below <= (a_i < b_i);
      flags_q.equal <= (a_i == b_i);
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import alu_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  flags_t            flags_i,
  output logic              taken_o,
  output logic              illegal_o
);
  logic above;
  assign above = ~flags_i.below & ~flags_i.equal;

  always_comb begin
    taken_o   = 1'b0;
    illegal_o = 1'b0;
    unique case (cond_i)
      CC_ALWAYS: taken_o = 1'b1;
      CC_EQ:     taken_o = flags_i.equal;
      CC_NE:     taken_o = ~flags_i.equal;
      CC_LT:     taken_o = flags_i.below;
      CC_LE:     taken_o = flags_i.below | flags_i.equal;
      CC_GT:     taken_o = above;
      CC_GE:     taken_o = ~flags_i.below;
      default:   illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_branch_unit.sv
module alu_branch_unit
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic [DATA_W-1:0] target_i,
  input  logic [DATA_W-1:0] fall_ip_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              valid_o,
  output logic              below_o,
  output logic              equal_o,
  output logic              taken_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] ip_o
);
  logic [DATA_W-1:0] dp_res;
  logic              dp_wr;
  logic              cc_taken, cc_bad;
  logic              is_cmp, is_jcc, is_bad;
  flags_t            flags;

  assign is_cmp = (op_i == OP_CMP);
  assign is_jcc = (op_i == OP_JCC);
  assign is_bad = (op_i == OP_BAD);

  alu_datapath #(.DATA_W(DATA_W)) i_dp (
    .op_i (op_i),
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(dp_res),
    .wr_o (dp_wr)
  );

  alu_flag_reg #(.DATA_W(DATA_W)) i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (start_i & is_cmp),
    .a_i    (a_i),
    .b_i    (b_i),
    .flags_o(flags)
  );

  alu_cond_eval i_cc (
    .cond_i   (cond_i),
    .flags_i  (flags),
    .taken_o  (cc_taken),
    .illegal_o(cc_bad)
  );

  logic [DATA_W-1:0] res_q, ip_q;
  logic              wr_q, valid_q, taken_q, bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      ip_q    <= '0;
      wr_q    <= 1'b0;
      valid_q <= 1'b0;
      taken_q <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      valid_q <= start_i;
      wr_q    <= start_i & dp_wr;
      taken_q <= start_i & is_jcc & cc_taken;
      bad_q   <= start_i & (is_bad | (is_jcc & cc_bad));
      if (start_i && dp_wr) res_q <= dp_res;
      if (start_i && is_jcc) ip_q <= cc_taken ? target_i : fall_ip_i;
    end
  end

  assign result_o  = res_q;
  assign ip_o      = ip_q;
  assign wr_en_o   = wr_q;
  assign valid_o   = valid_q;
  assign taken_o   = taken_q;
  assign illegal_o = bad_q;
  assign below_o   = flags.below;
  assign equal_o   = flags.equal;
endmodule

// File: rtl/alu_branch_unit_chk.sv
module alu_branch_unit_chk
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              valid_o,
  input logic              wr_en_o,
  input logic              below_o,
  input logic              equal_o,
  input logic              taken_o,
  input logic              illegal_o
);
  a_r1_valid_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o && !wr_en_o && !taken_o && !illegal_o);

  a_r4_cmp_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && op_i == OP_CMP |=> !wr_en_o);

  a_r4_cmp_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && op_i == OP_CMP |=> below_o == ($past(a_i) < $past(b_i))
                                  && equal_o == ($past(a_i) == $past(b_i)));

  a_r5_flags_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && op_i == OP_CMP) |=> $stable({below_o, equal_o}));

  a_r7_taken_not_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(taken_o && illegal_o));

  a_r9_bad_op_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && op_i == OP_BAD |=> illegal_o && !wr_en_o);

  a_r10_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(below_o && equal_o));
endmodule

bind alu_branch_unit alu_branch_unit_chk #(.DATA_W(DATA_W)) i_alu_branch_unit_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .valid_o  (valid_o),
  .wr_en_o  (wr_en_o),
  .below_o  (below_o),
  .equal_o  (equal_o),
  .taken_o  (taken_o),
  .illegal_o(illegal_o)
);

// File: tb/test_alu_branch_unit.sv
`timescale 1ns/1ps
module test_alu_branch_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [2:0]  cond_i = '0;
  logic [15:0] target_i = '0, fall_ip_i = '0;
  logic [15:0] result_o, ip_o;
  logic        wr_en_o, valid_o, below_o, equal_o, taken_o, illegal_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  alu_branch_unit i_alu_branch_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .cond_i(cond_i), .target_i(target_i),
    .fall_ip_i(fall_ip_i), .result_o(result_o), .wr_en_o(wr_en_o),
    .valid_o(valid_o), .below_o(below_o), .equal_o(equal_o),
    .taken_o(taken_o), .illegal_o(illegal_o), .ip_o(ip_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one request: drive at falling edge, outputs checked at the next falling edge
  task automatic issue(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [2:0] cc, input logic [15:0] tgt, input logic [15:0] fall);
    op_i = op; a_i = a; b_i = b; cond_i = cc; target_i = tgt; fall_ip_i = fall;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset valid", valid_o, 0);
    chk("R1 reset flags", {below_o, equal_o}, 0);
    chk("R1 reset result", result_o, 0);
    chk("R1 reset ip", ip_o, 0);
    chk("R1 reset pulses", {wr_en_o, taken_o, illegal_o}, 0);
  endtask

  task automatic t_arith();
    issue(3'b000, 16'hFFFF, 16'h0003, 0, 0, 0);
    chk("R2 add wrap", result_o, 16'h0002);
    chk("R2 add wr", wr_en_o, 1);
    chk("R1 valid pulse", valid_o, 1);
    @(negedge clk_i);
    chk("R1 valid single cycle", valid_o, 0);
    issue(3'b001, 16'h0001, 16'h0002, 0, 0, 0);
    chk("R2 sub wrap", result_o, 16'hFFFF);
    chk("R2 sub wr", wr_en_o, 1);
  endtask

  task automatic t_logic();
    issue(3'b010, 16'hF0F0, 16'h3C3C, 0, 0, 0);
    chk("R3 and", result_o, 16'h3030);
    issue(3'b011, 16'hF0F0, 16'h0F01, 0, 0, 0);
    chk("R3 or", result_o, 16'hFFF1);
    issue(3'b100, 16'h1234, 16'hFFFF, 0, 0, 0);
    chk("R3 not", result_o, 16'hEDCB);
    chk("R3 not wr", wr_en_o, 1);
  endtask

  task automatic t_cmp(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] prev;
    prev = result_o;
    issue(3'b101, a, b, 0, 0, 0);
    chk("R4 cmp no write", wr_en_o, 0);
    chk("R4 cmp result kept", result_o, {16'h0, prev} & 32'hFFFF);
    chk("R4 below", below_o, (a < b) ? 1 : 0);
    chk("R4 equal", equal_o, (a == b) ? 1 : 0);
    chk("R10 exclusive", below_o & equal_o, 0);
  endtask

  task automatic t_flags_held();
    t_cmp(16'h0010, 16'h8000);
    issue(3'b001, 16'h9000, 16'h0001, 0, 0, 0);
    chk("R5 held after sub", {below_o, equal_o}, 2'b10);
    issue(3'b110, 16'h0005, 16'h0005, 3'b000, 16'h0100, 16'h0200);
    chk("R5 held after jump", {below_o, equal_o}, 2'b10);
    repeat (3) @(negedge clk_i);
    chk("R5 held idle", {below_o, equal_o}, 2'b10);
  endtask

  function automatic logic exp_take(input logic [2:0] cc, input logic bl, input logic eq);
    case (cc)
      3'd0: return 1'b1;
      3'd1: return eq;
      3'd2: return !eq;
      3'd3: return bl;
      3'd4: return bl | eq;
      3'd5: return !bl && !eq;
      3'd6: return !bl;
      default: return 1'b0;
    endcase
  endfunction

  task automatic t_jumps(input logic [15:0] a, input logic [15:0] b);
    t_cmp(a, b);
    for (int c = 0; c < 8; c++) begin
      logic t;
      t = exp_take(c[2:0], a < b, a == b);
      issue(3'b110, 16'h0, 16'h0, c[2:0], 16'hA000 + 16'(c), 16'h1000 + 16'(c));
      if (c == 7) begin
        chk("R7 illegal cond", illegal_o, 1);
        chk("R7 not taken", taken_o, 0);
      end else begin
        chk("R6 taken", taken_o, t);
        chk("R6 not illegal", illegal_o, 0);
      end
      chk("R8 next ip", ip_o, t ? 16'hA000 + 16'(c) : 16'h1000 + 16'(c));
    end
    issue(3'b000, 16'h1, 16'h1, 0, 16'h5555, 16'h6666);
    chk("R8 ip held", ip_o, 16'h1007);
  endtask

  task automatic t_bad_op();
    logic [1:0] f;
    logic [15:0] r;
    f = {below_o, equal_o};
    r = result_o;
    issue(3'b111, 16'h0001, 16'h0002, 0, 0, 0);
    chk("R9 illegal op", illegal_o, 1);
    chk("R9 no write", wr_en_o, 0);
    chk("R9 result kept", result_o, r);
    chk("R9 flags kept", {below_o, equal_o}, f);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_arith();
    t_logic();
    t_cmp(16'h8000, 16'h7FFF);
    t_cmp(16'h4444, 16'h4444);
    t_flags_held();
    t_jumps(16'h0003, 16'h0009);
    t_jumps(16'h0009, 16'h0009);
    t_jumps(16'hFFFF, 16'h0000);
    t_bad_op();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule